// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block sits on the byte-wide register port of an eight-input interrupt controller. The port has two addresses. It takes synchronous write and read strobes and turns them into configuration state and single-cycle strobes for the request/priority core. Priority resolution is not done here. The core supplies the highest in-service line for non-specific end-of-interrupt and the winning pending line for poll reads.

Writes to address 0 fall into three kinds:
- An initialization opener, with bit 4 set. It resets the configuration and starts a sequence of up to three more data words at address 1. Two flags from the opener decide which of those words are skipped.
- A control word, with bit 4 clear and bit 3 set. It arms polling, chooses which register an address-0 read returns, and sets or clears special mask.
- An operation command, with bits 4 and 3 clear. Its top three bits choose between specific and non-specific end-of-interrupt, priority rotation, and setting the rotate-on-auto-EOI flag.

Outside the initialization sequence, address 1 holds the mask register. Reads are combinational in the cycle of the read strobe.

Top module: `irq_cmd_decoder`

## Requirements
- R1: A write at address 0 with bit 4 set does the following:
  - pulses `init_clr` for one cycle and moves `init_step` to 1;
  - latches bit 0 as the four-word flag and bit 1 as the single flag;
  - clears the mask, vector base, priority offset, read select, poll, special mask, rotate-on-auto-EOI, auto-EOI and nested-mode state.
- R2: `mode_err` rises when such an opener also has bit 3 set. It then stays high until reset.
- R3: A write at address 1 does one of the following, by step:
  - In step 0 it loads `irq_mask`.
  - In step 1 it loads `vec_base` from bits 7:3. The next step is 2 when the single flag is clear, otherwise 3 when the four-word flag is set, otherwise 0.
  - In step 2 it goes to 3 when the four-word flag is set, otherwise to 0.
  - In steps 1 to 3 the mask is left unchanged.
- R4: A write at address 1 in step 3 latches bit 4 into `nested_mode` and bit 1 into `auto_eoi`, then returns to step 0.
- R5: A control word is a write at address 0 with bit 4 clear and bit 3 set. Its bit 2 arms poll. Bit 0 sets the read select (1 selects in-service, 0 selects request), but only when bit 1 is set. Bit 5 sets `spec_mask`, but only when bit 6 is set.
- R6: Command 0 (bits 7:5 = 000) clears `rot_auto_eoi`. Command 4 (100) sets it.
- R7: Commands 1 (001) and 5 (101) are non-specific end-of-interrupt. When `svc_top_vld` is high, each pulses `clr_stb` for one cycle with `clr_line` = `svc_top_line`. Command 5 also sets `prio_ofs` to that line + 1 (mod 8). When `svc_top_vld` is low, neither command has any effect.
- R8: Command 3 (011) pulses `clr_stb` with `clr_line` = bits 2:0. Command 7 (111) does the same and also sets `prio_ofs` to bits 2:0 + 1 (mod 8).
- R9: Command 6 (110) sets `prio_ofs` to bits 2:0 + 1 (mod 8) and gives no clear strobe. Command 2 (010) changes nothing.
- R10: When poll is not armed, a read at address 1 returns `irq_mask`. A read at address 0 returns `svc_bits` when the read select is 1 and `req_bits` when it is 0.
- R11: When poll is armed, a read at either address does three things. It returns 0x80 OR `win_line` if `win_vld` is high, and 0x00 otherwise. If a line won, it pulses `ack_stb` the next cycle with `ack_line` = `win_line`. It disarms poll.
- R12: A poll acknowledge with `auto_eoi` and `rot_auto_eoi` both set moves `prio_ofs` to the acknowledged line + 1 (mod 8).
- R13: When a read and a write fall in the same cycle, the read returns the state before the write. A control word that arms poll in the same cycle as a poll read leaves poll armed. A command that sets `prio_ofs` takes precedence over a same-cycle acknowledge rotation.
- R14: After reset all outputs are 0, including `init_step` and `mode_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| req_bits | input | 8 | Request register from the core |
| svc_bits | input | 8 | In-service register from the core |
| svc_top_vld | input | 1 | Some in-service bit is set |
| svc_top_line | input | 3 | Highest-priority in-service line |
| win_vld | input | 1 | A pending line wins arbitration |
| win_line | input | 3 | Winning pending line |
| init_clr | output | 1 | One-cycle strobe: clear request/in-service state |
| clr_stb | output | 1 | One-cycle strobe: clear one in-service bit |
| clr_line | output | 3 | Line to clear with clr_stb |
| ack_stb | output | 1 | One-cycle poll acknowledge strobe |
| ack_line | output | 3 | Acknowledged line |
| irq_mask | output | 8 | Mask register |
| vec_base | output | 5 | Vector base, bits 7:3 of the vector |
| prio_ofs | output | 3 | Lowest-priority rotation offset |
| spec_mask | output | 1 | Special mask mode |
| auto_eoi | output | 1 | Automatic end-of-interrupt |
| rot_auto_eoi | output | 1 | Rotate on automatic end-of-interrupt |
| nested_mode | output | 1 | Special fully nested mode |
| init_step | output | 2 | Initialization step |
| mode_err | output | 1 | Sticky unsupported-mode flag |

## Verification
A poll read can fall in the same cycle as a write to the port, and that collision is provoked on purpose.

In the first case the read and a control word that re-arms poll are driven in one cycle. This is judged in three ways:
- the read data must be the poll result;
- an acknowledge must follow;
- a second read must again return a poll result rather than register contents.

In the second case a read of the mask and a mask write are driven in one cycle. The read must return the old mask and a later read the new one.

// File: rtl/irq_cmd_decoder.sv
module irq_cmd_decoder #(
  parameter int DW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic                      addr,
  input  logic [DW-1:0]             wdata,
  output logic [DW-1:0]             rdata,
  input  logic [DW-1:0]             req_bits,
  input  logic [DW-1:0]             svc_bits,
  input  logic                      svc_top_vld,
  input  logic [$clog2(DW)-1:0]     svc_top_line,
  input  logic                      win_vld,
  input  logic [$clog2(DW)-1:0]     win_line,
  output logic                      init_clr,
  output logic                      clr_stb,
  output logic [$clog2(DW)-1:0]     clr_line,
  output logic                      ack_stb,
  output logic [$clog2(DW)-1:0]     ack_line,
  output logic [DW-1:0]             irq_mask,
  output logic [DW-$clog2(DW)-1:0]  vec_base,
  output logic [$clog2(DW)-1:0]     prio_ofs,
  output logic                      spec_mask,
  output logic                      auto_eoi,
  output logic                      rot_auto_eoi,
  output logic                      nested_mode,
  output logic [1:0]                init_step,
  output logic                      mode_err
);
  localparam int LW = $clog2(DW);
  localparam logic [LW-1:0] ONE = LW'(1);

  logic four_q, single_q, poll_q, rsel_q;

  wire wr0     = wr_en & ~addr;
  wire wr1     = wr_en & addr;
  wire opener  = wr0 & wdata[4];
  wire ctl_wr  = wr0 & ~wdata[4] & wdata[3];
  wire cmd_wr  = wr0 & ~wdata[4] & ~wdata[3];
  wire [2:0] cmd = wdata[7:5];
  wire poll_rd = rd_en & poll_q;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (poll_q)
        rdata = win_vld ? {1'b1, {(DW-1-LW){1'b0}}, win_line} : '0;
      else if (addr)
        rdata = irq_mask;
      else
        rdata = rsel_q ? svc_bits : req_bits;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_clr     <= 1'b0;
      clr_stb      <= 1'b0;
      clr_line     <= '0;
      ack_stb      <= 1'b0;
      ack_line     <= '0;
      irq_mask     <= '0;
      vec_base     <= '0;
      prio_ofs     <= '0;
      spec_mask    <= 1'b0;
      auto_eoi     <= 1'b0;
      rot_auto_eoi <= 1'b0;
      nested_mode  <= 1'b0;
      init_step    <= 2'd0;
      mode_err     <= 1'b0;
      four_q       <= 1'b0;
      single_q     <= 1'b0;
      poll_q       <= 1'b0;
      rsel_q       <= 1'b0;
    end else begin
      init_clr <= 1'b0;
      clr_stb  <= 1'b0;
      ack_stb  <= 1'b0;

      if (poll_rd) begin
        poll_q <= 1'b0;
        if (win_vld) begin
          ack_stb  <= 1'b1;
          ack_line <= win_line;
          if (auto_eoi && rot_auto_eoi) prio_ofs <= win_line + ONE;
        end
      end

      if (opener) begin
        init_clr     <= 1'b1;
        init_step    <= 2'd1;
        four_q       <= wdata[0];
        single_q     <= wdata[1];
        mode_err     <= mode_err | wdata[3];
        irq_mask     <= '0;
        vec_base     <= '0;
        prio_ofs     <= '0;
        rsel_q       <= 1'b0;
        poll_q       <= 1'b0;
        spec_mask    <= 1'b0;
        rot_auto_eoi <= 1'b0;
        auto_eoi     <= 1'b0;
        nested_mode  <= 1'b0;
      end else if (ctl_wr) begin
        if (wdata[2]) poll_q    <= 1'b1;
        if (wdata[1]) rsel_q    <= wdata[0];
        if (wdata[6]) spec_mask <= wdata[5];
      end else if (cmd_wr) begin
        case (cmd)
          3'd0, 3'd4: rot_auto_eoi <= cmd[2];
          3'd1, 3'd5: if (svc_top_vld) begin
            clr_stb  <= 1'b1;
            clr_line <= svc_top_line;
            if (cmd[2]) prio_ofs <= svc_top_line + ONE;
          end
          3'd3: begin
            clr_stb  <= 1'b1;
            clr_line <= wdata[LW-1:0];
          end
          3'd6: prio_ofs <= wdata[LW-1:0] + ONE;
          3'd7: begin
            clr_stb  <= 1'b1;
            clr_line <= wdata[LW-1:0];
            prio_ofs <= wdata[LW-1:0] + ONE;
          end
          default: ;
        endcase
      end

      if (wr1) begin
        case (init_step)
          2'd0: irq_mask <= wdata;
          2'd1: begin
            vec_base  <= wdata[DW-1:LW];
            init_step <= !single_q ? 2'd2 : (four_q ? 2'd3 : 2'd0);
          end
          2'd2: init_step <= four_q ? 2'd3 : 2'd0;
          default: begin
            nested_mode <= wdata[4];
            auto_eoi    <= wdata[1];
            init_step   <= 2'd0;
          end
        endcase
      end
    end
  end
endmodule

module irq_cmd_decoder_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          addr,
  input logic [DW-1:0] wdata,
  input logic          svc_top_vld,
  input logic          win_vld,
  input logic          init_clr,
  input logic          clr_stb,
  input logic          ack_stb,
  input logic [DW-1:0] irq_mask,
  input logic [1:0]    init_step,
  input logic          mode_err,
  input logic          single_q,
  input logic          poll_q
);
  wire opener = wr_en && !addr && wdata[4];
  wire cmd_w  = wr_en && !addr && wdata[4:3] == 2'b00;
  wire rearm  = wr_en && !addr && wdata[4:3] == 2'b01 && wdata[2];

  AST_INIT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    opener |=> (init_step == 2'd1 && init_clr)); // R1
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> mode_err); // R2
  AST_MASK_FROZEN_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && init_step != 2'd0) |=> $stable(irq_mask)); // R3
  AST_SINGLE_SKIPS_STEP2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && init_step == 2'd1 && single_q) |=> init_step != 2'd2); // R3
  AST_CLR_FROM_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |-> $past(cmd_w)); // R7
  AST_NSEOI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && (wdata[7:5] == 3'd1 || wdata[7:5] == 3'd5) && !svc_top_vld) |=> !clr_stb); // R7
  AST_POLL_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll_q && !rearm) |=> !poll_q); // R11
  AST_ACK_FROM_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |-> $past(rd_en && poll_q && win_vld)); // R11
endmodule

bind irq_cmd_decoder irq_cmd_decoder_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .svc_top_vld(svc_top_vld), .win_vld(win_vld),
  .init_clr(init_clr), .clr_stb(clr_stb), .ack_stb(ack_stb),
  .irq_mask(irq_mask), .init_step(init_step), .mode_err(mode_err),
  .single_q(single_q), .poll_q(poll_q)
);

// File: tb/irq_cmd_decoder_test.sv
`timescale 1ns/1ps
module irq_cmd_decoder_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, addr = 0;
  logic [7:0] wdata = 0, rdata, req_bits = 0, svc_bits = 0;
  logic svc_top_vld = 0, win_vld = 0;
  logic [2:0] svc_top_line = 0, win_line = 0;
  logic init_clr, clr_stb, ack_stb, spec_mask, auto_eoi, rot_auto_eoi, nested_mode, mode_err;
  logic [2:0] clr_line, ack_line, prio_ofs;
  logic [7:0] irq_mask;
  logic [4:0] vec_base;
  logic [1:0] init_step;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq_cmd_decoder uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic t_reset;
    chk("R14 reset outputs", {init_clr, clr_stb, ack_stb, irq_mask, vec_base, prio_ofs,
        spec_mask, auto_eoi, rot_auto_eoi, nested_mode, init_step, mode_err}, 0);
  endtask

  task automatic t_init_full;
    logic [7:0] d;
    wr(1, 8'hFF);
    rd(1, d); chk("R3 mask write step0", d, 8'hFF);
    rd(0, d); chk("R10 read request", d, req_bits);
    wr(0, 8'h11);
    chk("R1 init strobe", init_clr, 1);
    chk("R1 step1", init_step, 1);
    chk("R1 mask cleared", irq_mask, 0);
    wr(1, 8'h48);
    chk("R3 base", vec_base, 5'h09);
    chk("R3 step2", init_step, 2);
    wr(1, 8'h77);
    chk("R3 step3 via four", init_step, 3);
    chk("R3 mask untouched", irq_mask, 0);
    wr(1, 8'h12);
    chk("R4 nested/aeoi", {nested_mode, auto_eoi}, 2'b11);
    chk("R4 back to step0", init_step, 0);
  endtask

  task automatic t_init_single;
    wr(0, 8'h12);
    chk("R1 flags cleared", {nested_mode, auto_eoi}, 0);
    wr(1, 8'h20);
    chk("R3 single no four -> step0", init_step, 0);
    wr(0, 8'h13);
    wr(1, 8'h08);
    chk("R3 single four -> step3", init_step, 3);
    wr(1, 8'h00);
    chk("R4 step3 exit", init_step, 0);
  endtask

  task automatic t_ctl_reads;
    logic [7:0] d;
    req_bits = 8'h3C; svc_bits = 8'h81;
    wr(1, 8'hA5);
    rd(1, d); chk("R10 mask read", d, 8'hA5);
    rd(0, d); chk("R10 request read", d, 8'h3C);
    wr(0, 8'h0B);
    rd(0, d); chk("R5 select in-service", d, 8'h81);
    wr(0, 8'h08);
    rd(0, d); chk("R5 select held without bit1", d, 8'h81);
    wr(0, 8'h0A);
    rd(0, d); chk("R5 select request", d, 8'h3C);
    wr(0, 8'h68); chk("R5 special mask set", spec_mask, 1);
    wr(0, 8'h28); chk("R5 special mask held", spec_mask, 1);
    wr(0, 8'h48); chk("R5 special mask clear", spec_mask, 0);
  endtask

  task automatic t_commands;
    wr(0, 8'h80); chk("R6 rotate set", rot_auto_eoi, 1);
    wr(0, 8'h00); chk("R6 rotate clear", rot_auto_eoi, 0);
    svc_top_vld = 1; svc_top_line = 5;
    wr(0, 8'h20);
    chk("R7 nonspecific clear", {clr_stb, clr_line}, {1'b1, 3'd5});
    chk("R7 offset unchanged", prio_ofs, 0);
    wr(0, 8'hA0);
    chk("R7 rotate clear", {clr_stb, clr_line, prio_ofs}, {1'b1, 3'd5, 3'd6});
    svc_top_vld = 0;
    wr(0, 8'hA0);
    chk("R7 no in-service no effect", {clr_stb, prio_ofs}, {1'b0, 3'd6});
    wr(0, 8'h63);
    chk("R8 specific clear", {clr_stb, clr_line, prio_ofs}, {1'b1, 3'd3, 3'd6});
    wr(0, 8'hE7);
    chk("R8 specific rotate wraps", {clr_stb, clr_line, prio_ofs}, {1'b1, 3'd7, 3'd0});
    wr(0, 8'hC4);
    chk("R9 set offset", {clr_stb, prio_ofs}, {1'b0, 3'd5});
    wr(0, 8'h47);
    chk("R9 command 2 no-op", {clr_stb, prio_ofs, rot_auto_eoi}, {1'b0, 3'd5, 1'b0});
  endtask

  task automatic t_poll;
    logic [7:0] d;
    win_vld = 1; win_line = 4;
    wr(0, 8'h0C);
    rd(1, d); chk("R11 poll data", d, 8'h84);
    chk("R11 ack strobe", {ack_stb, ack_line}, {1'b1, 3'd4});
    rd(1, d); chk("R11 poll disarmed", d, 8'hA5);
    chk("R11 single ack", ack_stb, 0);
    win_vld = 0;
    wr(0, 8'h0C);
    rd(0, d); chk("R11 poll none", d, 8'h00);
    chk("R11 no ack when none", ack_stb, 0);
    rd(1, d); chk("R11 disarmed after none", d, 8'hA5);
  endtask

  task automatic t_poll_rotate;
    logic [7:0] d;
    wr(0, 8'h13); wr(1, 8'h00); wr(1, 8'h02);
    chk("R4 auto-eoi on", auto_eoi, 1);
    wr(0, 8'h80);
    win_vld = 1; win_line = 2;
    wr(0, 8'h0C);
    rd(0, d); chk("R11 poll data", d, 8'h82);
    chk("R12 rotate on ack", prio_ofs, 3);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    win_line = 6;
    wr(0, 8'h0C);
    @(negedge clk); rd_en = 1; wr_en = 1; addr = 0; wdata = 8'h0C; #1 d = rdata;
    @(negedge clk); rd_en = 0; wr_en = 0;
    chk("R13 read sees poll", d, 8'h86);
    chk("R13 ack issued", {ack_stb, ack_line}, {1'b1, 3'd6});
    rd(1, d); chk("R13 poll stays armed", d, 8'h86);
    rd(1, d); chk("R13 mask after poll", d, 8'h00);
    @(negedge clk); rd_en = 1; wr_en = 1; addr = 1; wdata = 8'h3C; #1 d = rdata;
    @(negedge clk); rd_en = 0; wr_en = 0;
    chk("R13 read old mask", d, 8'h00);
    rd(1, d); chk("R13 new mask", d, 8'h3C);
  endtask

  task automatic t_error;
    wr(0, 8'h18);
    chk("R2 error raised", mode_err, 1);
    chk("R1 step1", init_step, 1);
    wr(1, 8'h00); wr(1, 8'h00);
    chk("R3 no four step2 -> 0", init_step, 0);
    chk("R2 error sticky", mode_err, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_init_full();
    t_init_single();
    t_ctl_reads();
    t_commands();
    t_poll();
    t_poll_rotate();
    t_collide();
    t_error();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule